// File: doc/BRIEF.md
# RGB to YCbCr Color Converter

This block turns a stream of 10-bit RGB pixels into 10-bit YCbCr pixels. Each input component first gets a signed offset and is limited to a programmable window. A 3x3 matrix of signed fixed-point weights then mixes the three components. Each sum is rounded, shifted down to pixel scale, given a signed output offset and limited to a second programmable window per output channel. Out of reset the block holds a limited-range conversion set, so it produces usable YCbCr without any programming.

Pixels enter and leave through valid/ready handshakes, and the three-stage pipeline stalls as a whole when the consumer holds off. Software fills a shadow copy of the settings through a small write port. A frame-start pulse moves the shadow copy into the working copy. The move waits until every pixel already inside the pipeline has left it, and the input is held off until then. A frame is therefore never processed with two different sets of weights.

Top module: `rgb2ycc_conv`

## Requirements
- R1: During and after synchronous active-low reset, out_valid is 0, in_ready is 1, and both the shadow and working settings hold the default set of R5.
- R2: Each input component (index 0 = R, 1 = G, 2 = B) has an 11-bit two's-complement input offset added to it. The result is then limited to that component's 10-bit window [low, high].
- R3: Output channel c (0 = Y, 1 = Cb, 2 = Cr) is the sum over k of weight[3c+k] times limited component k. Each weight is 13-bit two's-complement, and 512 stands for 1.0. The sum is rounded half-up: 256 is added, then the value is shifted arithmetically right by 9.
- R4: The rounded value of each output channel has an 11-bit two's-complement output offset added to it. The result is then limited to that channel's 10-bit window [low, high].
- R5: The default weights are Y = {0x083, 0x102, 0x032}, Cb = {0x1FB5, 0x1F6C, 0x0E1} and Cr = {0x0E1, 0x1F45, 0x1FDC}. Input offsets default to 0, and the input windows to 0x000..0x3FF. Output offsets default to Y 0x040 and Cb/Cr 0x200. Output windows default to Y 0x040..0x3AC and Cb/Cr 0x040..0x3C0.
- R6: With out_ready held high, a pixel accepted at clock edge n is shown on out_valid and the data outputs from edge n+2 on.
- R7: While out_valid is 1 and out_ready is 0, out_valid and all output data stay unchanged. Every accepted pixel leaves exactly once, and in order.
- R8: A write (cfg_we = 1) changes only the shadow settings. Address map: 0..8 are the weights, row-major (address 3c+k). 9..11 are the input offsets for R, G, B. 12..14 are the output offsets for Y, Cb, Cr. 15..17 are the input window lows and 18..20 the input window highs. 21..23 are the output window lows and 24..26 the output window highs. Values are taken from the low bits of cfg_wdata.
- R9: A frame_start pulse sets a pending commit. From the next cycle, in_ready is 0 until the pipeline is empty. The shadow settings then become the working settings. Pixels accepted up to and including the cycle of the pulse use the old settings, and later pixels use the new ones.
- R10: Writes to addresses 27 and above change no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel accepted this cycle if in_valid |
| in_r | input | 10 | Red component |
| in_g | input | 10 | Green component |
| in_b | input | 10 | Blue component |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_y | output | 10 | Luma |
| out_cb | output | 10 | Blue-difference chroma |
| out_cr | output | 10 | Red-difference chroma |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 5 | Setting address |
| cfg_wdata | input | 16 | Setting value (low bits used) |
| frame_start | input | 1 | Request to commit shadow settings |

## Verification
The range assertion on the outputs takes for granted that every output window has its low bound at or below its high bound. Every setting the stimulus writes keeps low at or below high. The stall and commit properties assume that frame_start is a single-cycle pulse and that no setting is written while a commit is pending, and the stimulus does both. Pixels cover a grid that includes 0, 1 and 0x3FF on every component, plus random values. The stimulus uses random output back-pressure and a second setting set with negative weights, negative offsets and narrowed input windows.

// File: rtl/rgb2ycc_pkg.sv
// Shared widths, the settings record and the default limited-range set.
// Assumes 10-bit pixels and 13-bit weights with 9 fractional bits.
package rgb2ycc_pkg;
    localparam int PIX_W  = 10;
    localparam int COEF_W = 13;
    localparam int FRAC   = 9;
    localparam int BIAS_W = PIX_W + 1;
    localparam int ACC_W  = PIX_W + 1 + COEF_W + 2;
    localparam int ADDR_W = 5;
    localparam int CFG_DW = 16;
    localparam int NREG   = 27;

    typedef struct packed {
        logic [8:0][COEF_W-1:0] coef;
        logic [2:0][BIAS_W-1:0] pre_bias;
        logic [2:0][BIAS_W-1:0] post_bias;
        logic [2:0][PIX_W-1:0]  pre_lo;
        logic [2:0][PIX_W-1:0]  pre_hi;
        logic [2:0][PIX_W-1:0]  post_lo;
        logic [2:0][PIX_W-1:0]  post_hi;
    } cfg_t;

    // Limited-range conversion set loaded at reset.
    function automatic cfg_t default_cfg();
        cfg_t c;
        c.coef[0] = 13'h0083; c.coef[1] = 13'h0102; c.coef[2] = 13'h0032;
        c.coef[3] = 13'h1FB5; c.coef[4] = 13'h1F6C; c.coef[5] = 13'h00E1;
        c.coef[6] = 13'h00E1; c.coef[7] = 13'h1F45; c.coef[8] = 13'h1FDC;
        c.pre_bias     = '0;
        c.post_bias[0] = 11'h040;
        c.post_bias[1] = 11'h200;
        c.post_bias[2] = 11'h200;
        c.pre_lo       = '0;
        for (int i = 0; i < 3; i++) begin
            c.pre_hi[i]  = 10'h3FF;
            c.post_lo[i] = 10'h040;
        end
        c.post_hi[0] = 10'h3AC;
        c.post_hi[1] = 10'h3C0;
        c.post_hi[2] = 10'h3C0;
        return c;
    endfunction
endpackage

// File: rtl/rgb2ycc_cfg.sv
// Shadow and working settings with a deferred commit.
// Writes land in the shadow copy. A frame_start pulse arms a commit that
// fires once the pipeline reports empty.
module rgb2ycc_cfg
    import rgb2ycc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = CFG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          frame_start,
    input  logic          pipe_empty,
    output cfg_t          active,
    output logic          pend,
    output logic          commit
);
    localparam int GRP_W = AW;

    cfg_t             shadow;
    logic [GRP_W-1:0] grp;
    logic [1:0]       sub;

    // Split the address into a three-entry group and an index inside it.
    always_comb begin
        grp    = addr / AW'(3);
        sub    = 2'(addr % AW'(3));
        commit = pend && pipe_empty;
    end

    // Shadow register file, written by the setting port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= default_cfg();
        end else if (we) begin
            case (grp)
                AW'(0), AW'(1), AW'(2): shadow.coef[4'(addr)] <= wdata[COEF_W-1:0];
                AW'(3): shadow.pre_bias[sub]  <= wdata[BIAS_W-1:0];
                AW'(4): shadow.post_bias[sub] <= wdata[BIAS_W-1:0];
                AW'(5): shadow.pre_lo[sub]    <= wdata[PIX_W-1:0];
                AW'(6): shadow.pre_hi[sub]    <= wdata[PIX_W-1:0];
                AW'(7): shadow.post_lo[sub]   <= wdata[PIX_W-1:0];
                AW'(8): shadow.post_hi[sub]   <= wdata[PIX_W-1:0];
                default: ;
            endcase
        end
    end

    // Working copy and pending flag for the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= default_cfg();
            pend   <= 1'b0;
        end else begin
            if (commit) active <= shadow;
            pend <= frame_start | (pend & ~pipe_empty);
        end
    end
endmodule

// File: rtl/rgb2ycc_pre.sv
// Stage 1, one component: add a signed offset, limit to [lo, hi], register.
// Assumes lo <= hi for a meaningful window.
module rgb2ycc_pre #(
    parameter int PW = 10,
    parameter int BW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [PW-1:0] pix,
    input  logic [BW-1:0] bias,
    input  logic [PW-1:0] lo,
    input  logic [PW-1:0] hi,
    output logic [PW-1:0] q
);
    localparam int SW = PW + 2;

    logic signed [SW-1:0] s;
    logic [PW-1:0]        c;

    // Offset the component, then limit it to the window.
    always_comb begin
        s = $signed({2'b00, pix}) + $signed({{(SW-BW){bias[BW-1]}}, bias});
        if (s < $signed({2'b00, lo}))      c = lo;
        else if (s > $signed({2'b00, hi})) c = hi;
        else                               c = s[PW-1:0];
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= c;
    end
endmodule

// File: rtl/rgb2ycc_mac.sv
// Stage 2, one output row: signed dot product of three weights with three
// unsigned components, registered. AW must hold three full products.
module rgb2ycc_mac #(
    parameter int PW = 10,
    parameter int CW = 13,
    parameter int AW = PW + 1 + CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic [2:0][CW-1:0]   row,
    input  logic [2:0][PW-1:0]   x,
    output logic signed [AW-1:0] acc_q
);
    logic signed [AW-1:0] sum;

    // Sum of the three products at full width.
    always_comb begin
        logic signed [AW-1:0] cx;
        logic signed [AW-1:0] xx;
        sum = '0;
        for (int k = 0; k < 3; k++) begin
            cx  = AW'($signed(row[k]));
            xx  = AW'({1'b0, x[k]});
            sum = sum + cx * xx;
        end
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (ld) acc_q <= sum;
    end
endmodule

// File: rtl/rgb2ycc_post.sv
// Stage 3, one channel: round half-up, drop FR fraction bits, add the
// signed offset, limit to [lo, hi], register.
module rgb2ycc_post #(
    parameter int PW = 10,
    parameter int BW = PW + 1,
    parameter int AW = 26,
    parameter int FR = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic signed [AW-1:0] acc,
    input  logic [BW-1:0]        bias,
    input  logic [PW-1:0]        lo,
    input  logic [PW-1:0]        hi,
    output logic [PW-1:0]        q
);
    logic signed [AW-1:0] rnd;
    logic signed [AW-1:0] v;
    logic [PW-1:0]        c;

    // Round, rescale, offset and limit.
    always_comb begin
        rnd = (acc + AW'(2 ** (FR - 1))) >>> FR;
        v   = rnd + AW'($signed(bias));
        if (v < $signed(AW'({1'b0, lo})))      c = lo;
        else if (v > $signed(AW'({1'b0, hi}))) c = hi;
        else                                   c = v[PW-1:0];
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= c;
    end
endmodule

// File: rtl/rgb2ycc_conv.sv
// Top: three-stage RGB to YCbCr pipeline with valid/ready on both sides.
// The stall chain is combinational from out_ready back to in_ready.
// Input is held off while a settings commit is pending.
module rgb2ycc_conv
    import rgb2ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_y,
    output logic [PIX_W-1:0]  out_cb,
    output logic [PIX_W-1:0]  out_cr,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              frame_start
);
    cfg_t                          act;
    logic                          cfg_pend;
    logic                          cfg_commit;
    logic                          pipe_empty;
    logic                          v1, v2, v3;
    logic                          ld1, ld2, ld3;
    logic [2:0][PIX_W-1:0]         pix_in;
    logic [2:0][PIX_W-1:0]         x1;
    logic signed [ACC_W-1:0]       acc2 [3];
    logic [2:0][PIX_W-1:0]         q3;

    // Stage load enables, input acceptance and the empty flag.
    always_comb begin
        ld3        = !v3 || out_ready;
        ld2        = !v2 || ld3;
        ld1        = !v1 || ld2;
        in_ready   = ld1 && !cfg_pend;
        pipe_empty = !v1 && !v2 && !v3;
        pix_in     = {in_b, in_g, in_r};
    end

    // Valid bits moving through the three stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else begin
            if (ld1) v1 <= in_valid && in_ready;
            if (ld2) v2 <= v1;
            if (ld3) v3 <= v2;
        end
    end

    rgb2ycc_cfg #(.AW(ADDR_W), .DW(CFG_DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .frame_start(frame_start), .pipe_empty(pipe_empty),
        .active(act), .pend(cfg_pend), .commit(cfg_commit)
    );

    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
        rgb2ycc_pre #(.PW(PIX_W), .BW(BIAS_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .ld(ld1), .pix(pix_in[ch]),
            .bias(act.pre_bias[ch]), .lo(act.pre_lo[ch]), .hi(act.pre_hi[ch]),
            .q(x1[ch])
        );
        rgb2ycc_mac #(.PW(PIX_W), .CW(COEF_W), .AW(ACC_W)) u_mac (
            .clk(clk), .rst_n(rst_n), .ld(ld2), .row(act.coef[3*ch +: 3]),
            .x(x1), .acc_q(acc2[ch])
        );
        rgb2ycc_post #(.PW(PIX_W), .BW(BIAS_W), .AW(ACC_W), .FR(FRAC)) u_post (
            .clk(clk), .rst_n(rst_n), .ld(ld3), .acc(acc2[ch]),
            .bias(act.post_bias[ch]), .lo(act.post_lo[ch]), .hi(act.post_hi[ch]),
            .q(q3[ch])
        );
    end

    // Output view of the last stage.
    always_comb begin
        out_valid = v3;
        out_y     = q3[0];
        out_cb    = q3[1];
        out_cr    = q3[2];
    end
endmodule

// File: rtl/rgb2ycc_conv_chk.sv
// Protocol and range checker bound to the converter top.
// Assumes output windows with low <= high and single-cycle frame_start.
module rgb2ycc_conv_chk
    import rgb2ycc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_cb,
    input logic [PIX_W-1:0] out_cr,
    input logic             frame_start,
    input logic             cfg_pend,
    input cfg_t             act
);
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid)
        else $error("reset left out_valid high");

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_cb) && $stable(out_cr))
        else $error("output changed under stall");

    p_arm_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> cfg_pend)
        else $error("frame_start did not arm commit");

    p_hold_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pend |-> !in_ready)
        else $error("input accepted during pending commit");

    p_out_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_y  >= act.post_lo[0] && out_y  <= act.post_hi[0] &&
                       out_cb >= act.post_lo[1] && out_cb <= act.post_hi[1] &&
                       out_cr >= act.post_lo[2] && out_cr <= act.post_hi[2]))
        else $error("output outside window");
endmodule

bind rgb2ycc_conv rgb2ycc_conv_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr),
    .frame_start(frame_start), .cfg_pend(cfg_pend), .act(act)
);

// File: tb/rgb2ycc_conv_bench.sv
`timescale 1ns/1ps
module rgb2ycc_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [9:0]  in_r = '0, in_g = '0, in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [9:0]  out_y, out_cb, out_cr;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    bit    bp = 0;
    bit    in_fired;
    bit    hold_pend = 0;
    int    hold_val;
    int    sh [27];
    int    ac [27];
    int    exp_q [$];
    string tag_q [$];
    string cur_tag = "R5";

    always #4 clk = ~clk;

    rgb2ycc_conv u_rgb2ycc_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start)
    );

    function automatic int sx(int v, int w);
        return ((v >> (w - 1)) & 1) ? v - (1 << w) : v;
    endfunction

    function automatic int lim(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Expected output per R2..R4, from the bench's working settings.
    function automatic int model(int r, int g, int b);
        int p [3];
        int x [3];
        int res = 0;
        p[0] = r; p[1] = g; p[2] = b;
        for (int k = 0; k < 3; k++)
            x[k] = lim(p[k] + sx(ac[9 + k], 11), ac[15 + k], ac[18 + k]);
        for (int c = 0; c < 3; c++) begin
            int s = 0;
            int v;
            for (int k = 0; k < 3; k++) s += sx(ac[3 * c + k], 13) * x[k];
            v = ((s + 256) >>> 9) + sx(ac[12 + c], 11);
            res = (res << 10) | lim(v, ac[21 + c], ac[24 + c]);
        end
        return res;
    endfunction

    task automatic check(bit ok, string req, string what, int act_v, int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act_v, exp_v);
        end
    endtask

    // One cycle: runs at a negedge, scores the handshakes of the next edge.
    task automatic tick();
        int got;
        out_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
        #1;
        got = {2'b00, out_y, out_cb, out_cr};
        if (hold_pend) begin
            check(out_valid == 1'b1, "R7", "valid dropped under stall", int'(out_valid), 1);
            check(got == hold_val, "R7", "data moved under stall", got, hold_val);
        end
        hold_pend = out_valid && !out_ready;
        hold_val  = got;
        if (in_valid && in_ready) begin
            exp_q.push_back(model(in_r, in_g, in_b));
            tag_q.push_back(cur_tag);
            in_fired = 1;
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected output", got, 0);
            end else begin
                int e = exp_q.pop_front();
                string t = tag_q.pop_front();
                check(got == e, t, "pixel", got, e);
            end
        end
        if (cfg_we && cfg_addr < 27) begin
            int a = cfg_addr;
            int m = (a < 9) ? 'h1FFF : (a < 15) ? 'h7FF : 'h3FF;
            sh[a] = cfg_wdata & m;
        end
        if (frame_start) ac = sh;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(int r, int g, int b);
        in_valid = 1; in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
        in_fired = 0;
        while (!in_fired) tick();
        in_valid = 0;
    endtask

    task automatic wr(int a, int d);
        cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
        tick();
        cfg_we = 0;
    endtask

    task automatic drain();
        bp = 0;
        while (exp_q.size() > 0) tick();
        tick();
    endtask

    initial begin
        int dflt [27] = '{'h083, 'h102, 'h032, 'h1FB5, 'h1F6C, 'h0E1, 'h0E1, 'h1F45, 'h1FDC,
                          0, 0, 0, 'h040, 'h200, 'h200, 0, 0, 0, 'h3FF, 'h3FF, 'h3FF,
                          'h040, 'h040, 'h040, 'h3AC, 'h3C0, 'h3C0};
        int grid [8] = '{0, 1, 'h100, 'h155, 'h200, 'h2AA, 'h3FE, 'h3FF};
        sh = dflt;
        ac = dflt;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        // R1: idle state right after reset
        check(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);

        // R6: latency of an isolated pixel; R5 white clamps luma to 0x3AC
        cur_tag = "R5";
        send('h3FF, 'h3FF, 'h3FF);
        check(out_valid == 0, "R6", "valid one edge early", int'(out_valid), 0);
        tick();
        check(out_valid == 0, "R6", "valid at edge n+1", int'(out_valid), 0);
        tick();
        check(out_valid == 1, "R6", "valid at edge n+2", int'(out_valid), 1);
        check(out_y == 10'h3AC, "R5", "white luma ceiling", int'(out_y), 'h3AC);
        drain();

        // R2 R3 R4 R5 R7: default set over a grid with random back-pressure
        cur_tag = "R3";
        bp = 1;
        foreach (grid[i]) foreach (grid[j]) foreach (grid[k])
            send(grid[i], grid[j], grid[k]);
        drain();

        // R8: shadow writes alone leave outputs on the default set
        wr(0, 'h200); wr(1, 'h101); wr(2, 0);
        wr(3, 0); wr(4, 'h200); wr(5, 0);
        wr(6, 0); wr(7, 0); wr(8, 'h1E00);
        wr(9, 'h7E0); wr(10, 'h010); wr(11, 0);
        wr(12, 0); wr(13, 'h7F0); wr(14, 'h3FF);
        wr(15, 'h010); wr(16, 0); wr(17, 0);
        wr(18, 'h3FF); wr(19, 'h300); wr(20, 'h3FF);
        wr(21, 0); wr(22, 0); wr(23, 0);
        wr(24, 'h3FF); wr(25, 'h3FF); wr(26, 'h3FF);
        // R10: out-of-map addresses
        wr(27, 'h1234); wr(31, 'hFFFF);
        cur_tag = "R8";
        for (int i = 0; i < 6; i++) send(grid[i], grid[7 - i], grid[(i * 3) % 8]);

        // R9: commit while pixels are in flight
        in_valid = 1; in_r = 10'h123; in_g = 10'h2F0; in_b = 10'h077;
        frame_start = 1; in_fired = 0;
        tick();
        frame_start = 0;
        check(in_ready == 0, "R9", "in_ready during pending commit", int'(in_ready), 0);
        cur_tag = "R9";
        if (!in_fired) send(in_r, in_g, in_b);
        in_valid = 0;

        // R2 R4 R10: new set at corners and random values
        cur_tag = "R10";
        for (int m = 0; m < 8; m++)
            send((m & 1) ? 'h3FF : 0, (m & 2) ? 'h3FF : 0, (m & 4) ? 'h3FF : 0);
        cur_tag = "R2";
        bp = 1;
        for (int i = 0; i < 300; i++)
            send($urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023));
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog expired: actual 0x%0h expected 0x%0h", exp_q.size(), 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule